// File: doc/BRIEF.md
# Banked System Control Register File

This block stores the control, identification and status words of a processor core. It offers one register-index access port. A read returns the selected word in the same cycle, and a write updates it on the next rising clock edge. A separate current-mode input tells the block which privilege mode the core is in. That input decides which physical copy a saved-status access reaches.

Each register applies its own write rule. Some store the written word unchanged. Some accept only certain bits. One keeps a protected bit. The identification words ignore writes. A synchronous clear request loads every register with its defined start value, and the asynchronous reset does the same. The system control word takes part of its start value from a reset-configuration word. That word survives a clear and is zeroed only by the asynchronous reset. The status word reads back with two execution-state bits taken from inputs in place of the stored bits.

Top module: `sysreg_bank_top`

## Requirements
- R1: Index map: 0 status, 1 saved-status, 2 to 7 the saved-status copies for FIQ, IRQ, supervisor, monitor, abort and undefined modes, 8 system control, 9 coprocessor access, 10 FP exception, 11 main ID, 12 TLB type, 13 and 14 media feature 0 and 1, 15 multiprocessor ID, 16 FP ID, 17 event mailbox, 18 reset-configuration. An access to index 1 is steered to a copy by `curMode`: 0x11 to index 2, 0x12 to 3, 0x13 to 4, 0x16 to 5, 0x17 to 6, 0x1B to 7. Indices 2 to 7 are also reachable directly.
- R2: When `curMode` is user (0x10), system (0x1F) or any other unlisted value, index 1 reaches the unbanked saved-status word.
- R3: Writes to indices 12, 13, 14, 15 and 16 leave their contents unchanged.
- R4: A write to the FP exception word (10) changes only bits 30:29. Every other bit keeps its old value.
- R5: A write to system control (8) stores the written word except bit 27, which keeps its old value.
- R6: A write to coprocessor access (9) keeps only bits 23:20 of the written word. All other bits become 0.
- R7: Reset and clear values: status 0x00000010, mailbox 0x1, TLB type 0x1, main ID 0x350F0000, coprocessor access 0x00F00000, media feature 0 0x11110222, media feature 1 0x01111111. All saved-status words, FP exception, multiprocessor ID and FP ID reset to 0.
- R8: On reset or clear, system control becomes 0x00450050, which sets bits 22, 18, 16, 6 and 4. Bits 27 and 13 are then copied from the reset-configuration word (18). A clear leaves word 18 as it is, and the asynchronous reset sets it to 0.
- R9: A read of index 0 returns the stored status word with bit 24 replaced by `jState` and bit 5 replaced by `tState`.
- R10: An index of 19 or above reads as 0 and raises `accErr` while `rdEn` or `wrEn` is high. A write to such an index changes no register.
- R11: When `clearReq` and a write fall in the same cycle, the clear wins and the write is dropped.
- R12: Indices 0 to 7, 11, 17 and 18 store the full written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clearReq | input | 1 | Synchronous clear to start values |
| curMode | input | 5 | Current processor mode code |
| jState | input | 1 | Execution-state bit returned at status bit 24 |
| tState | input | 1 | Execution-state bit returned at status bit 5 |
| regIdx | input | 5 | Register index for read and write |
| rdEn | input | 1 | Read access qualifier (for the error flag) |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the indexed register |
| accErr | output | 1 | Access to an unimplemented index |

## Verification
The clear request and a register write can fall in the same clock cycle. This matters most for a saved-status write under a banked mode, or a write to the reset-configuration word just before the system control value is rebuilt from it. The random stream raises a clear in about one cycle in thirty-two with writes enabled. Directed cases also pair a clear with a mailbox write. The result is judged by reading the target back in the following cycle and expecting the start value, not the written word.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = 5;
  localparam int MODE_W   = 5;
  localparam int NUM_REGS = 19;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [DATA_W-1:0] word_t;
  typedef logic [MODE_W-1:0] mode_t;

  localparam idx_t IDX_STATUS    = 5'd0;
  localparam idx_t IDX_SAVED     = 5'd1;
  localparam idx_t IDX_SAVED_FIQ = 5'd2;
  localparam idx_t IDX_SAVED_IRQ = 5'd3;
  localparam idx_t IDX_SAVED_SVC = 5'd4;
  localparam idx_t IDX_SAVED_MON = 5'd5;
  localparam idx_t IDX_SAVED_ABT = 5'd6;
  localparam idx_t IDX_SAVED_UND = 5'd7;
  localparam idx_t IDX_SYSCTL    = 5'd8;
  localparam idx_t IDX_CPACC     = 5'd9;
  localparam idx_t IDX_FPEXC     = 5'd10;
  localparam idx_t IDX_MAINID    = 5'd11;
  localparam idx_t IDX_TLBTYPE   = 5'd12;
  localparam idx_t IDX_MEDIA0    = 5'd13;
  localparam idx_t IDX_MEDIA1    = 5'd14;
  localparam idx_t IDX_MPID      = 5'd15;
  localparam idx_t IDX_FPID      = 5'd16;
  localparam idx_t IDX_MAILBOX   = 5'd17;
  localparam idx_t IDX_RSTCFG    = 5'd18;

  localparam mode_t MODE_USR = 5'h10;
  localparam mode_t MODE_FIQ = 5'h11;
  localparam mode_t MODE_IRQ = 5'h12;
  localparam mode_t MODE_SVC = 5'h13;
  localparam mode_t MODE_MON = 5'h16;
  localparam mode_t MODE_ABT = 5'h17;
  localparam mode_t MODE_UND = 5'h1B;
  localparam mode_t MODE_SYS = 5'h1F;

  localparam int STAT_J_BIT   = 24;
  localparam int STAT_T_BIT   = 5;
  localparam int CTL_NMFI_BIT = 27;
  localparam int CTL_V_BIT    = 13;

  localparam word_t CTL_BASE     = 32'h0045_0050;
  localparam word_t CTL_CFG_MASK = (word_t'(1) << CTL_NMFI_BIT) | (word_t'(1) << CTL_V_BIT);
  localparam word_t FPEXC_WMASK  = 32'h6000_0000;
  localparam word_t CPACC_KEEP   = 32'h00F0_0000;
  localparam word_t MAINID_INIT  = 32'h350F_0000;
  localparam word_t MEDIA0_INIT  = 32'h1111_0222;
  localparam word_t MEDIA1_INIT  = 32'h0111_1111;

  typedef struct packed {
    idx_t physIdx;
    logic wrStrobe;
    logic inRange;
    logic clr;
  } strobe_t;

  function automatic word_t writeRule(idx_t id, word_t d, word_t old);
    word_t v;
    v = d;
    case (id)
      IDX_FPEXC:  v = (d & FPEXC_WMASK) | (old & ~FPEXC_WMASK);
      IDX_SYSCTL: v[CTL_NMFI_BIT] = old[CTL_NMFI_BIT];
      IDX_CPACC:  v = d & CPACC_KEEP;
      IDX_TLBTYPE, IDX_MEDIA0, IDX_MEDIA1, IDX_MPID, IDX_FPID: v = old;
      default: v = d;
    endcase
    return v;
  endfunction

  function automatic word_t resetRule(idx_t id, word_t cfg);
    word_t v;
    case (id)
      IDX_STATUS:  v = word_t'(MODE_USR);
      IDX_SYSCTL:  v = CTL_BASE | (cfg & CTL_CFG_MASK);
      IDX_CPACC:   v = CPACC_KEEP;
      IDX_MAINID:  v = MAINID_INIT;
      IDX_TLBTYPE: v = word_t'(1);
      IDX_MEDIA0:  v = MEDIA0_INIT;
      IDX_MEDIA1:  v = MEDIA1_INIT;
      IDX_MAILBOX: v = word_t'(1);
      default:     v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/sysreg_ctrl.sv
module sysreg_ctrl
  import sysreg_pkg::*;
(
  input  idx_t    regIdx,
  input  mode_t   curMode,
  input  logic    rdEn,
  input  logic    wrEn,
  input  logic    clearReq,
  output strobe_t strobe,
  output logic    accErr
);
  idx_t bankIdx;
  logic inRange;

  always_comb begin
    case (curMode)
      MODE_FIQ: bankIdx = IDX_SAVED_FIQ;
      MODE_IRQ: bankIdx = IDX_SAVED_IRQ;
      MODE_SVC: bankIdx = IDX_SAVED_SVC;
      MODE_MON: bankIdx = IDX_SAVED_MON;
      MODE_ABT: bankIdx = IDX_SAVED_ABT;
      MODE_UND: bankIdx = IDX_SAVED_UND;
      default:  bankIdx = IDX_SAVED;
    endcase
  end

  assign inRange = (int'(regIdx) < NUM_REGS);

  always_comb begin
    strobe.physIdx  = (regIdx == IDX_SAVED) ? bankIdx : regIdx;
    strobe.inRange  = inRange;
    strobe.clr      = clearReq;
    strobe.wrStrobe = wrEn & inRange & ~clearReq;
  end

  assign accErr = (rdEn | wrEn) & ~inRange;
endmodule

// File: rtl/sysreg_data.sv
module sysreg_data
  import sysreg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strobe,
  input  word_t   wrData,
  input  logic    jState,
  input  logic    tState,
  output word_t   rdData
);
  word_t regQ [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam idx_t ID = idx_t'(g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ[g] <= resetRule(ID, '0);
      end else if (strobe.clr) begin
        if (ID != IDX_RSTCFG) regQ[g] <= resetRule(ID, regQ[IDX_RSTCFG]);
      end else if (strobe.wrStrobe && strobe.physIdx == ID) begin
        regQ[g] <= writeRule(ID, wrData, regQ[g]);
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (strobe.inRange && strobe.physIdx == idx_t'(i)) rdData = regQ[i];
    end
    if (strobe.inRange && strobe.physIdx == IDX_STATUS) begin
      rdData[STAT_J_BIT] = jState;
      rdData[STAT_T_BIT] = tState;
    end
  end

  // R4: only the writable FP exception bits may move on a write
  a_r4_fpexc_mask: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStrobe && strobe.physIdx == IDX_FPEXC) |=>
      ((regQ[IDX_FPEXC] & ~FPEXC_WMASK) == ($past(regQ[IDX_FPEXC]) & ~FPEXC_WMASK)));

  a_r3_ro_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStrobe && strobe.physIdx == IDX_TLBTYPE) |=> $stable(regQ[IDX_TLBTYPE]));

  a_r5_nmfi_keep: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStrobe && strobe.physIdx == IDX_SYSCTL) |=> $stable(regQ[IDX_SYSCTL][CTL_NMFI_BIT]));

  a_r6_cpacc_clean: assert property (@(posedge clk) disable iff (!rstN)
    (regQ[IDX_CPACC] & ~CPACC_KEEP) == '0);

  a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (regQ[IDX_MAILBOX] == word_t'(1)));
endmodule

// File: rtl/sysreg_bank_top.sv
module sysreg_bank_top
  import sysreg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clearReq,
  input  logic [4:0]  curMode,
  input  logic        jState,
  input  logic        tState,
  input  logic [4:0]  regIdx,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        accErr
);
  strobe_t strobe;

  sysreg_ctrl u_ctrl (
    .regIdx   (regIdx),
    .curMode  (curMode),
    .rdEn     (rdEn),
    .wrEn     (wrEn),
    .clearReq (clearReq),
    .strobe   (strobe),
    .accErr   (accErr)
  );

  sysreg_data u_data (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .jState (jState),
    .tState (tState),
    .rdData (rdData)
  );

  // R10: an unimplemented index never returns data
  a_r10_oob_zero: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> (rdData == '0));
endmodule

// File: tb/tb_sysreg_bank_top.sv
`timescale 1ns/1ps
module tb_sysreg_bank_top;
  import sysreg_pkg::*;

  localparam int NREG = 19;

  logic        clk = 0;
  logic        rstN = 0;
  logic        clearReq = 0;
  logic [4:0]  curMode = 5'h10;
  logic        jState = 0;
  logic        tState = 0;
  logic [4:0]  regIdx = 0;
  logic        rdEn = 0;
  logic        wrEn = 0;
  logic [31:0] wrData = 0;
  logic [31:0] rdData;
  logic        accErr;

  int checks = 0;
  int failures = 0;
  logic [31:0] mdl [0:NREG-1];

  sysreg_bank_top dut (.*);

  always #4 clk = ~clk;

  function automatic int physOf(input logic [4:0] idx, input logic [4:0] md);
    if (idx != 5'd1) return int'(idx);
    case (md)
      5'h11: return 2;
      5'h12: return 3;
      5'h13: return 4;
      5'h16: return 5;
      5'h17: return 6;
      5'h1B: return 7;
      default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] expWrite(input int id, input logic [31:0] d, input logic [31:0] old);
    case (id)
      10: return (d & 32'h6000_0000) | (old & 32'h9FFF_FFFF);
      8:  return {d[31:28], old[27], d[26:0]};
      9:  return {8'h00, d[23:20], 20'h0};
      12, 13, 14, 15, 16: return old;
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] expReset(input int id, input logic [31:0] cfg);
    case (id)
      0:  return 32'h10;
      8:  return 32'h0045_0050 | {4'h0, cfg[27], 13'h0, cfg[13], 13'h0};
      9:  return 32'h00F0_0000;
      11: return 32'h350F_0000;
      12: return 32'h1;
      13: return 32'h1111_0222;
      14: return 32'h0111_1111;
      17: return 32'h1;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(input int p);
    case (p)
      0: return "R9";
      1: return "R2";
      2, 3, 4, 5, 6, 7: return "R1";
      8: return "R5";
      9: return "R6";
      10: return "R4";
      12, 13, 14, 15, 16: return "R3";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic doOp(input logic [4:0] idx, input logic we, input logic [31:0] d,
                      input logic [4:0] md, input logic clr, input string tag);
    int p;
    logic [31:0] e;
    @(negedge clk);
    regIdx = idx; wrEn = we; rdEn = 1'b1; wrData = d; curMode = md; clearReq = clr;
    jState = 1'($urandom_range(0, 1)); tState = 1'($urandom_range(0, 1));
    #1;
    p = physOf(idx, md);
    e = 32'h0;
    if (int'(idx) < NREG) begin
      e = mdl[p];
      if (p == 0) begin e[24] = jState; e[5] = tState; end
    end
    chk(tag, rdData, e);
    chk((int'(idx) < NREG) ? tag : "R10", {31'b0, accErr}, {31'b0, (int'(idx) >= NREG)});
    @(posedge clk);
    if (clr) begin
      for (int i = 0; i < NREG; i++) if (i != 18) mdl[i] = expReset(i, mdl[18]);
    end else if (we && int'(idx) < NREG) begin
      mdl[p] = expWrite(p, d, mdl[p]);
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [4:0] modes [9];
    modes = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h16, 5'h17, 5'h1B, 5'h1F, 5'h05};
    void'($urandom(32'd20240611));
    for (int i = 0; i < NREG; i++) mdl[i] = expReset(i, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R7 R8: reset state of every register
    for (int i = 0; i < NREG; i++) doOp(5'(i), 1'b0, 32'h0, 5'h10, 1'b0, (i == 8) ? "R8" : "R7");

    // R1: saved-status writes per banked mode, read back directly
    for (int m = 1; m < 7; m++) doOp(5'd1, 1'b1, 32'hA500_0000 + 32'(m), modes[m], 1'b0, "R1");
    for (int i = 2; i < 8; i++) doOp(5'(i), 1'b0, 32'h0, 5'h10, 1'b0, "R1");
    // R2: user, system and unknown modes reach the base copy
    doOp(5'd1, 1'b1, 32'h1234_5678, 5'h1F, 1'b0, "R2");
    doOp(5'd1, 1'b0, 32'h0, 5'h05, 1'b0, "R2");
    doOp(5'd1, 1'b0, 32'h0, 5'h10, 1'b0, "R2");
    // R3: identification words ignore writes
    for (int i = 12; i < 17; i++) begin
      doOp(5'(i), 1'b1, 32'hFFFF_FFFF, 5'h10, 1'b0, "R3");
      doOp(5'(i), 1'b0, 32'h0, 5'h10, 1'b0, "R3");
    end
    // R4 R5 R6 masked writes
    doOp(5'd10, 1'b1, 32'hFFFF_FFFF, 5'h10, 1'b0, "R4");
    doOp(5'd10, 1'b0, 32'h0, 5'h10, 1'b0, "R4");
    doOp(5'd8, 1'b1, 32'hFFFF_FFFF, 5'h10, 1'b0, "R5");
    doOp(5'd8, 1'b0, 32'h0, 5'h10, 1'b0, "R5");
    doOp(5'd9, 1'b1, 32'h0F3C_FFFF, 5'h10, 1'b0, "R6");
    doOp(5'd9, 1'b0, 32'h0, 5'h10, 1'b0, "R6");
    // R10: out-of-range write and read
    doOp(5'd25, 1'b1, 32'hDEAD_BEEF, 5'h10, 1'b0, "R10");
    doOp(5'd31, 1'b0, 32'h0, 5'h10, 1'b0, "R10");
    // R8: clear rebuilds system control from the configuration word
    doOp(5'd18, 1'b1, 32'hFFFF_FFFF, 5'h10, 1'b0, "R12");
    doOp(5'd17, 1'b1, 32'h0000_ABCD, 5'h10, 1'b1, "R11");
    doOp(5'd17, 1'b0, 32'h0, 5'h10, 1'b0, "R11");
    doOp(5'd8, 1'b0, 32'h0, 5'h10, 1'b0, "R8");
    doOp(5'd18, 1'b0, 32'h0, 5'h10, 1'b0, "R8");
    // R9: status read with state bits
    doOp(5'd0, 1'b1, 32'hFFFF_FFFF, 5'h10, 1'b0, "R12");
    doOp(5'd0, 1'b0, 32'h0, 5'h10, 1'b0, "R9");
    doOp(5'd0, 1'b0, 32'h0, 5'h10, 1'b0, "R9");

    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic [4:0] idx;
      logic [4:0] md;
      logic clr;
      idx = ($urandom_range(0, 15) == 0) ? 5'($urandom_range(19, 31)) : 5'($urandom_range(0, 18));
      md = modes[$urandom_range(0, 8)];
      clr = ($urandom_range(0, 31) == 0);
      doOp(idx, 1'($urandom_range(0, 1)), $urandom, md, clr,
           clr ? "R11" : ((int'(idx) < NREG) ? tagOf(physOf(idx, md)) : "R10"));
    end

    @(negedge clk);
    wrEn = 0; rdEn = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule